// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This block is a memory-mapped system watchdog. Software programs a single control word once after power-on reset. That word sets a 16-bit time count, whether the timer runs, what expiry does, whether a fixed prescaler slows the count, and whether an external debug-freeze pin may stall the timer. Once started, a down-counter runs from the time count toward zero.

The counter is restored to the time count only by a two-key service sequence written to a 16-bit service register. Any other traffic on that register leaves the counter alone. When the counter reaches zero, the block emits a one-cycle pulse. In interrupt mode the pulse goes to `irq` and the counter restarts. In reset mode the pulse goes to `rst_req` and the counter stops for good.

A reset-mode expiry also sets a sticky cause flag. That flag survives everything except power-on reset and a write-one-to-clear. Software reads the live counter through a read-only count register. The bus is a plain single-cycle port: writes take effect on the clock edge and reads are combinational from the address.

Top module: `keyed_wdt`

## Requirements
- R1: After power-on reset (`rst_n` low) every register reads 0, `irq` and `rst_req` are low and the counter is idle.
- R2: The control register sits at byte address 0x0. Its fields are: time count in bits 31:16, freeze-enable in bit 3, enable in bit 2, expiry select in bit 1 and prescale-enable in bit 0. The other bits read 0. Only the first write after power-on reset is stored; every later write to it is ignored entirely.
- R3: The counter loads the effective time count on the write that enables it and on every valid service sequence. A time count of 0 loads 65536. The count register at address 0x4 returns the counter in bits 16:0.
- R4: A service is a write of 0x556C followed by a write of 0xAA39 to bits 15:0 at address 0x8. Idle cycles between the two writes are allowed. 0xAA39 without a directly preceding 0x556C does nothing. Any other value written between the two keys cancels the sequence.
- R5: With prescale-enable clear the counter decrements every clock. With it set, the counter decrements once per PRESCALE_DIV (default 65536) clocks, counted from the last load.
- R6: Expiry happens on the decrement from 1 and produces a one-cycle pulse. With select = 0 the pulse is on `irq`, and the counter reloads and keeps running. With select = 1 the pulse is on `rst_req`, and the counter stays at 0 and ignores service until power-on reset.
- R7: A reset-mode expiry sets bit 0 of the status register at 0x0C. Writing 1 to that bit clears it; writing 0 leaves it set.
- R8: While freeze-enable is set and `freeze_in` is high, the counter and prescaler hold. With freeze-enable clear, `freeze_in` has no effect.
- R9: If the first control write leaves enable clear, the counter stays at 0 and never produces a pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| freeze_in | input | 1 | External debug-freeze request |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 4 | Byte address (bits 3:2 select the register) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq | output | 1 | One-cycle interrupt-mode expiry pulse |
| rst_req | output | 1 | One-cycle reset-mode expiry pulse |

## Verification
Some rules are checked by the assertions on every cycle. The control word cannot change once stored. The key tracker arms only on the first key and disarms on anything else. Every load takes the presented span, and each tick steps the count down by one. A freeze holds the counter, and a halted counter never moves again. The sticky flag only drops on a clear write, and a disabled timer stays silent.

Other behaviours only the directed scenarios can show, because they depend on whole timelines. These are the exact expiry cycle counts with and without the prescaler, the effective span of a zero time count, and the swapped and interrupted key orders. The bench also shows that service after a reset-mode expiry does nothing.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam int TC_W  = 16;
  localparam int CNT_W = TC_W + 1;

  localparam logic [15:0] SVC_KEY_A = 16'h556C;
  localparam logic [15:0] SVC_KEY_B = 16'hAA39;

  localparam logic [1:0] REG_CTRL  = 2'd0;
  localparam logic [1:0] REG_COUNT = 2'd1;
  localparam logic [1:0] REG_SVC   = 2'd2;
  localparam logic [1:0] REG_STAT  = 2'd3;

  typedef struct packed {
    logic [TC_W-1:0] tc;
    logic            frz;
    logic            en;
    logic            sel_rst;
    logic            pre;
  } wdt_cfg_t;

  // effective number of decrements for a programmed time count
  function automatic logic [CNT_W-1:0] reload_span(input logic [TC_W-1:0] tc);
    if (tc == '0) return {1'b1, {TC_W{1'b0}}};
    return {1'b0, tc};
  endfunction

  function automatic wdt_cfg_t cfg_from_word(input logic [31:0] w);
    wdt_cfg_t c;
    c.tc      = w[31:16];
    c.frz     = w[3];
    c.en      = w[2];
    c.sel_rst = w[1];
    c.pre     = w[0];
    return c;
  endfunction

  function automatic logic [31:0] word_from_cfg(input wdt_cfg_t c);
    return {c.tc, 12'h000, c.frz, c.en, c.sel_rst, c.pre};
  endfunction

endpackage

// File: rtl/wdt_cfg_reg.sv
module wdt_cfg_reg
  import wdt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctrl_wr,
  input  logic [31:0] ctrl_wdata,
  input  logic        stat_wr,
  input  logic        stat_clr,
  input  logic        rst_evt,
  output wdt_cfg_t    cfg,
  output logic        locked,
  output logic        start,
  output logic        sticky
);

  wdt_cfg_t incoming;
  assign incoming = cfg_from_word(ctrl_wdata);

  // first accepted write that turns the timer on
  assign start = ctrl_wr && !locked && incoming.en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg    <= '0;
      locked <= 1'b0;
    end else if (ctrl_wr && !locked) begin
      cfg    <= incoming;
      locked <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 sticky <= 1'b0;
    else if (rst_evt)           sticky <= 1'b1;
    else if (stat_wr && stat_clr) sticky <= 1'b0;
  end

  a_r2_write_once: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> (locked && $stable(cfg)));

  a_r7_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky && !(stat_wr && stat_clr)) |=> sticky);

  a_r7_sticky_sets: assert property (@(posedge clk) disable iff (!rst_n)
    rst_evt |=> sticky);

endmodule

// File: rtl/wdt_key_seq.sv
module wdt_key_seq
  import wdt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        svc_wr,
  input  logic [15:0] svc_data,
  output logic        armed,
  output logic        reload
);

  logic hit_a, hit_b;
  assign hit_a = (svc_data == SVC_KEY_A);
  assign hit_b = (svc_data == SVC_KEY_B);

  assign reload = svc_wr && hit_b && armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      armed <= 1'b0;
    else if (svc_wr) armed <= hit_a;
  end

  a_r4_arm_on_first_key: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_wr && svc_data == SVC_KEY_A) |=> armed);

  a_r4_other_write_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_wr && svc_data != SVC_KEY_A) |=> !armed);

  a_r4_idle_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
    !svc_wr |=> $stable(armed));

endmodule

// File: rtl/wdt_down_cnt.sv
module wdt_down_cnt
  import wdt_pkg::*;
#(
  parameter int PRESCALE_DIV = 65536
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             pre_en,
  input  logic             hold,
  input  logic             sel_rst,
  output logic [CNT_W-1:0] cnt,
  output logic             halted,
  output logic             tick,
  output logic             irq_p,
  output logic             rst_p
);

  logic active;
  assign active = run && !halted && !hold;

  generate
    if (PRESCALE_DIV > 1) begin : g_pre
      localparam int PW = $clog2(PRESCALE_DIV);
      localparam logic [PW-1:0] PRE_LAST = PW'(PRESCALE_DIV - 1);
      logic [PW-1:0] pre_q;
      logic          pre_wrap;
      assign pre_wrap = (pre_q == PRE_LAST);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 pre_q <= '0;
        else if (load && !halted)   pre_q <= '0;
        else if (active && pre_en)  pre_q <= pre_wrap ? '0 : pre_q + 1'b1;
      end
      assign tick = active && (!pre_en || pre_wrap);
    end else begin : g_nopre
      assign tick = active;
    end
  endgenerate

  logic expire;
  assign expire = tick && (cnt == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      halted <= 1'b0;
      irq_p  <= 1'b0;
      rst_p  <= 1'b0;
    end else begin
      irq_p <= 1'b0;
      rst_p <= 1'b0;
      if (halted) begin
        cnt <= cnt;
      end else if (load) begin
        cnt <= load_val;
      end else if (expire) begin
        if (sel_rst) begin
          rst_p  <= 1'b1;
          halted <= 1'b1;
          cnt    <= '0;
        end else begin
          irq_p <= 1'b1;
          cnt   <= load_val;
        end
      end else if (tick) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  a_r3_load_takes_span: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !halted) |=> (cnt == $past(load_val)));

  a_r5_tick_steps_down: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && cnt > CNT_W'(1)) |=> (cnt == $past(cnt) - 1'b1));

  a_r8_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !load) |=> $stable(cnt));

  a_r6_reset_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    rst_p |=> !rst_p);

  a_r6_halt_is_final: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && $stable(cnt) && !irq_p));

  a_r6_one_action: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_p && rst_p));

endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import wdt_pkg::*;
#(
  parameter int PRESCALE_DIV = 65536
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        freeze_in,
  input  logic        bus_wr,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq,
  output logic        rst_req
);

  logic [1:0] sel;
  assign sel = bus_addr[3:2];

  logic ctrl_wr, svc_wr, stat_wr;
  assign ctrl_wr = bus_wr && (sel == REG_CTRL);
  assign svc_wr  = bus_wr && (sel == REG_SVC);
  assign stat_wr = bus_wr && (sel == REG_STAT);

  wdt_cfg_t         cfg;
  logic             locked, start, sticky;
  logic             armed, key_reload;
  logic [CNT_W-1:0] cnt_val, load_val;
  logic             halted, tick, irq_p, rst_p;

  wdt_cfg_reg u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_wr    (ctrl_wr),
    .ctrl_wdata (bus_wdata),
    .stat_wr    (stat_wr),
    .stat_clr   (bus_wdata[0]),
    .rst_evt    (rst_p),
    .cfg        (cfg),
    .locked     (locked),
    .start      (start),
    .sticky     (sticky)
  );

  wdt_key_seq u_keys (
    .clk      (clk),
    .rst_n    (rst_n),
    .svc_wr   (svc_wr),
    .svc_data (bus_wdata[15:0]),
    .armed    (armed),
    .reload   (key_reload)
  );

  logic svc_load, cnt_load, frozen;
  assign svc_load = key_reload && cfg.en;
  assign cnt_load = start || svc_load;
  assign frozen   = cfg.frz && freeze_in;
  // on the enabling write the stored word is not yet visible
  assign load_val = start ? reload_span(bus_wdata[31:16]) : reload_span(cfg.tc);

  wdt_down_cnt #(.PRESCALE_DIV(PRESCALE_DIV)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (cfg.en),
    .load     (cnt_load),
    .load_val (load_val),
    .pre_en   (cfg.pre),
    .hold     (frozen),
    .sel_rst  (cfg.sel_rst),
    .cnt      (cnt_val),
    .halted   (halted),
    .tick     (tick),
    .irq_p    (irq_p),
    .rst_p    (rst_p)
  );

  always_comb begin
    unique case (sel)
      REG_CTRL:  bus_rdata = word_from_cfg(cfg);
      REG_COUNT: bus_rdata = {{(32-CNT_W){1'b0}}, cnt_val};
      REG_SVC:   bus_rdata = '0;
      default:   bus_rdata = {31'd0, sticky};
    endcase
  end

  assign irq     = irq_p;
  assign rst_req = rst_p;

  logic unused_bits;
  assign unused_bits = ^{bus_addr[1:0], bus_wdata[15:4], armed, locked, tick};

  a_r9_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg.en |-> (cnt_val == '0 && !irq && !rst_req));

  a_r6_halt_blocks_service: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && svc_load) |=> (cnt_val == '0));

endmodule

// File: tb/sim_keyed_wdt.sv
module sim_keyed_wdt;

  localparam int DIV = 65536;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        freeze_in = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = 4'h0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, rst_req;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  keyed_wdt #(.PRESCALE_DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .freeze_in(freeze_in), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .rst_req(rst_req)
  );

  localparam logic [3:0] A_CTRL = 4'h0, A_CNT = 4'h4, A_SVC = 4'h8, A_STAT = 4'hC;

  function automatic logic [31:0] span(input logic [15:0] tc);
    return (tc == 16'd0) ? 32'd65536 : {16'd0, tc};
  endfunction

  function automatic logic [31:0] ctl(input logic [15:0] tc, input logic frz,
                                      input logic en, input logic rs, input logic pr);
    return {tc, 12'd0, frz, en, rs, pr};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic por();
    rst_n = 1'b0; bus_wr = 1'b0; freeze_in = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(1);
  endtask

  // counts negedges until the chosen pulse appears, or limit
  task automatic measure(input bit want_rst, input int limit, output int k);
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!(want_rst ? rst_req : irq) && k < limit);
    if (!(want_rst ? rst_req : irq)) k = -1;
  endtask

  task automatic t_reset_state();
    logic [31:0] d;
    por();
    rd(A_CTRL, d); chk("R1 ctrl after reset", d, 0);
    rd(A_CNT, d);  chk("R1 count after reset", d, 0);
    rd(A_STAT, d); chk("R1 status after reset", d, 0);
    chk("R1 outputs after reset", {30'd0, irq, rst_req}, 0);
  endtask

  task automatic t_irq_plain();
    logic [31:0] d; int k;
    por();
    freeze_in = 1'b1;                       // no effect: freeze-enable clear (R8)
    wr(A_CTRL, ctl(16'd5, 0, 1, 0, 0));
    rd(A_CNT, d); chk("R3 load on enable", d, span(16'd5));
    measure(0, 20, k); chk("R5 R8 irq after 5 clocks", k, 5);
    chk("R6 no reset pulse in irq mode", {31'd0, rst_req}, 0);
    @(negedge clk); chk("R6 irq single cycle", {31'd0, irq}, 0);
    measure(0, 20, k); chk("R6 irq mode reloads and repeats", k, 4);
    wr(A_CTRL, ctl(16'd9, 0, 0, 1, 1));
    rd(A_CTRL, d); chk("R2 second control write ignored", d, ctl(16'd5, 0, 1, 0, 0));
    measure(0, 10, k); chk("R2 still running after ignored write", {31'd0, k > 0 && k <= 5}, 1);
    freeze_in = 1'b0;
  endtask

  task automatic t_keys();
    logic [31:0] d; int k;
    por();
    wr(A_CTRL, ctl(16'd50, 0, 1, 0, 0));
    idle(5);
    rd(A_CNT, d); chk("R5 plain decrement", d, 45);
    wr(A_SVC, 32'h0000AA39);
    wr(A_SVC, 32'h0000556C);
    rd(A_CNT, d); chk("R4 swapped keys do not reload", d, 43);
    wr(A_SVC, 32'h00001234);
    wr(A_SVC, 32'h0000AA39);
    rd(A_CNT, d); chk("R4 interrupted sequence does not reload", d, 41);
    wr(A_SVC, 32'h0000556C);
    idle(2);
    wr(A_SVC, 32'h0000AA39);
    rd(A_CNT, d); chk("R4 R3 valid service reloads", d, 50);
    measure(0, 80, k); chk("R4 expiry after service", k, 50);
  endtask

  task automatic t_reset_mode();
    logic [31:0] d; int k;
    por();
    wr(A_CTRL, ctl(16'd3, 0, 1, 1, 0));
    measure(1, 20, k); chk("R6 reset pulse after 3 clocks", k, 3);
    chk("R6 no irq in reset mode", {31'd0, irq}, 0);
    idle(2);
    rd(A_STAT, d); chk("R7 sticky set by reset expiry", d, 1);
    rd(A_CNT, d);  chk("R6 counter stopped at zero", d, 0);
    wr(A_SVC, 32'h0000556C);
    wr(A_SVC, 32'h0000AA39);
    rd(A_CNT, d);  chk("R6 service ignored after reset expiry", d, 0);
    measure(1, 20, k); chk("R6 no second reset pulse", k, -1);
    wr(A_STAT, 32'h0);
    rd(A_STAT, d); chk("R7 writing zero keeps flag", d, 1);
    wr(A_STAT, 32'h1);
    rd(A_STAT, d); chk("R7 writing one clears flag", d, 0);
  endtask

  task automatic t_disabled();
    logic [31:0] d; int k;
    por();
    wr(A_CTRL, ctl(16'd7, 0, 0, 0, 0));
    rd(A_CNT, d); chk("R9 disabled counter idle", d, 0);
    wr(A_CTRL, ctl(16'd4, 0, 1, 0, 0));
    rd(A_CTRL, d); chk("R2 enable cannot be set later", d, ctl(16'd7, 0, 0, 0, 0));
    measure(0, 20, k); chk("R9 no pulse while disabled", k, -1);
    rd(A_CNT, d); chk("R9 counter still zero", d, 0);
  endtask

  task automatic t_zero_count();
    logic [31:0] d;
    por();
    wr(A_CTRL, ctl(16'd0, 0, 1, 0, 0));
    rd(A_CNT, d); chk("R3 zero time count means 65536", d, span(16'd0));
    idle(1);
    rd(A_CNT, d); chk("R5 first decrement from 65536", d, 32'd65535);
  endtask

  task automatic t_freeze();
    logic [31:0] d; int k;
    por();
    freeze_in = 1'b1;
    wr(A_CTRL, ctl(16'd10, 1, 1, 0, 0));
    idle(6);
    rd(A_CNT, d); chk("R8 frozen counter holds", d, 10);
    freeze_in = 1'b0;
    measure(0, 30, k); chk("R8 resumes after freeze", k, 10);
  endtask

  task automatic t_pre_irq();
    logic [31:0] d;
    por();
    wr(A_CTRL, ctl(16'd1, 0, 1, 0, 1));
    idle(DIV - 1);
    rd(A_CNT, d); chk("R5 prescaled count not yet stepped", d, 1);
    chk("R5 no early irq with prescaler", {31'd0, irq}, 0);
    @(negedge clk);
    chk("R5 R6 prescaled irq expiry", {31'd0, irq}, 1);
  endtask

  task automatic t_pre_rst();
    int k;
    por();
    wr(A_CTRL, ctl(16'd1, 0, 1, 1, 1));
    measure(1, DIV + 100, k); chk("R5 R6 prescaled reset expiry", k, DIV);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
  end

  initial begin
    t_reset_state();
    t_irq_plain();
    t_keys();
    t_reset_mode();
    t_disabled();
    t_zero_count();
    t_freeze();
    t_pre_irq();
    t_pre_rst();
    summary();
  end

endmodule